// File: doc/BRIEF.md
# Triggered DMA Request Generator Channel

This block is one channel of a DMA request generator. A single 32-bit control register chooses one of the trigger lines, the kind of edge to watch for, and a burst length. The chosen line is brought into the clock domain through a short synchronizer chain. When the chosen edge is seen while the channel is enabled, the channel raises its request toward the DMA controller. It keeps the request high until it has received the programmed number of acknowledges, and then goes quiet until the next edge.

Trigger codes beyond the last real line are reserved and never fire. The burst-length field cannot be changed while the channel is enabled. An edge that arrives while a burst is still outstanding is not served. Instead it sets a sticky overrun flag, which can drive an interrupt. Clearing the enable bit cancels the current burst at once.

Top module: `dtg_channel`

## Requirements
- R1: After reset the control register reads 0, and the request, overrun flag and interrupt outputs are 0. A read returns the trigger select in bits 4:0, the overrun interrupt enable in bit 8, the channel enable in bit 16, the edge mode in bits 18:17 and the burst count in bits 23:19. Every other bit reads 0.
- R2: Select codes 0 to 29 pick the trigger line of the same index. Codes 30 and 31 never produce a trigger event, whatever the trigger lines do.
- R3: Edge mode 1 fires on a rising edge of the selected line, mode 2 on a falling edge, and mode 3 on either edge. Mode 0 never fires.
- R4: A trigger event taken while no burst is outstanding produces exactly count+1 acknowledged requests. After that the request stays low until the next event.
- R5: A write to the count field (bits 23:19) is ignored while the stored enable bit is 1. The other fields of that same write still take effect.
- R6: A trigger event that arrives while a burst is outstanding sets the overrun flag.
- R7: The interrupt output is 1 exactly when the overrun flag is 1 and the overrun interrupt enable bit is 1.
- R8: The overrun flag stays set until the clear strobe is applied. The event that caused it neither lengthens nor restarts the current burst.
- R9: A write that clears the enable bit drops the request on the same clock edge and discards the remaining requests. Re-enabling afterwards starts nothing until a new edge arrives.
- R10: Once the request is raised, it stays high until the acknowledge input is sampled high. Each sampled acknowledge uses up one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data |
| trig_vec_i | input | 32 | Trigger lines, asynchronous to the clock |
| dreq_o | output | 1 | DMA request |
| dack_i | input | 1 | DMA acknowledge |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Overrun flag clear strobe |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The embedded assertions check the cycle-level rules on every clock edge:
- the request is held until it is acknowledged;
- there is no request while the channel is disabled;
- the overrun flag is sticky, and it can only rise while a burst is outstanding;
- the count field stays frozen while the channel is enabled.

Only the directed scenarios can show the end-to-end behaviour:
- the exact number of requests in a burst;
- which edge modes and select codes fire, and which stay silent;
- that a dropped overrun event does not lengthen the burst;
- the exact bit layout seen on read-back.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Field positions in the control word; software depends on them.
  localparam int SEL_LSB  = 0;
  localparam int OIE_BIT  = 8;
  localparam int EN_BIT   = 16;
  localparam int MODE_LSB = 17;
  localparam int CNT_LSB  = 19;
  localparam int WORD_W   = 32;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

endpackage

// File: rtl/dtg_cfg_reg.sv
module dtg_cfg_reg
  import dtg_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              oie_o,
  output logic              en_o,
  output edge_mode_e        mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dis_wr_o
);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             oie_q, oie_d;
  logic             en_q, en_d;
  edge_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_wr_ok;

  // Burst length is only writable while the channel is idle (disabled).
  assign cnt_wr_ok = we_i & ~en_q;

  always_comb begin
    sel_d  = sel_q;
    oie_d  = oie_q;
    en_d   = en_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (we_i) begin
      sel_d  = wdata_i[SEL_LSB +: SEL_W];
      oie_d  = wdata_i[OIE_BIT];
      en_d   = wdata_i[EN_BIT];
      mode_d = edge_mode_e'(wdata_i[MODE_LSB +: 2]);
    end
    if (cnt_wr_ok) begin
      cnt_d = wdata_i[CNT_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      oie_q  <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= EDGE_NONE;
      cnt_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      oie_q  <= oie_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[SEL_LSB +: SEL_W]  = sel_q;
    rdata_o[OIE_BIT]           = oie_q;
    rdata_o[EN_BIT]            = en_q;
    rdata_o[MODE_LSB +: 2]     = mode_q;
    rdata_o[CNT_LSB +: CNT_W]  = cnt_q;
  end

  assign sel_o    = sel_q;
  assign oie_o    = oie_q;
  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign cnt_o    = cnt_q;
  assign dis_wr_o = we_i & ~wdata_i[EN_BIT];

  AST_CNT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/dtg_edge_detect.sv
module dtg_edge_detect
  import dtg_pkg::*;
#(
  parameter int SEL_W       = 5,
  parameter int NUM_VALID   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2**SEL_W-1:0]  trig_vec_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  edge_mode_e           mode_i,
  input  logic                 en_i,
  output logic                 evt_o
);

  localparam int NUM_IN = 2**SEL_W;

  logic                   pick;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   synced, rise, fall;

  // Reserved codes map to a constant low line.
  assign pick = (int'(sel_i) < NUM_VALID) ? trig_vec_i[sel_i] : 1'b0;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign sync_d = pick;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pick};
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];
  assign prev_d = synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: evt_o = en_i & rise;
      EDGE_FALL: evt_o = en_i & fall;
      EDGE_ANY:  evt_o = en_i & (rise | fall);
      default:   evt_o = 1'b0;
    endcase
  end

  if (NUM_IN < NUM_VALID) begin : g_bad_cfg
    initial $error("NUM_VALID exceeds trigger vector width");
  end

  AST_NO_EVT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_NONE) |-> !evt_o); // R3

endmodule

// File: rtl/dtg_burst_ctrl.sv
module dtg_burst_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kill_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dack_i,
  input  logic             ovr_clr_i,
  output logic             dreq_o,
  output logic             ovr_o
);

  localparam int LEFT_W = CNT_W + 1;

  logic [LEFT_W-1:0] left_q, left_d;
  logic              ovr_q, ovr_d;
  logic              busy, load, step, ovr_set;

  assign busy    = (left_q != '0);
  assign load    = evt_i & ~busy;
  assign step    = busy & dack_i;
  assign ovr_set = evt_i & busy;

  always_comb begin
    left_d = left_q;
    if (kill_i || !en_i) begin
      left_d = '0;
    end else if (load) begin
      left_d = LEFT_W'(cnt_i) + LEFT_W'(1);
    end else if (step) begin
      left_d = left_q - LEFT_W'(1);
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_clr_i) ovr_d = 1'b0;
    if (ovr_set)   ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      ovr_q  <= ovr_d;
    end
  end

  assign dreq_o = busy;
  assign ovr_o  = ovr_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_o && !dack_i && en_i && !kill_i) |=> dreq_o); // R10
  AST_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !dreq_o); // R9
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q); // R8
  AST_OVR_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(dreq_o)); // R6

endmodule

// File: rtl/dtg_channel.sv
module dtg_channel
  import dtg_pkg::*;
#(
  parameter int SEL_W       = 5,
  parameter int CNT_W       = 5,
  parameter int NUM_VALID   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic [31:0] trig_vec_i,
  output logic        dreq_o,
  input  logic        dack_i,
  output logic        ovr_flag_o,
  input  logic        ovr_clr_i,
  output logic        irq_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [SEL_W-1:0] sel;
  logic             oie, en, dis_wr, evt;
  edge_mode_e       mode;
  logic [CNT_W-1:0] cnt;
  logic             ovr;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dtg_cfg_reg #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .sel_o   (sel),
    .oie_o   (oie),
    .en_o    (en),
    .mode_o  (mode),
    .cnt_o   (cnt),
    .dis_wr_o(dis_wr)
  );

  dtg_edge_detect #(.SEL_W(SEL_W), .NUM_VALID(NUM_VALID), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .trig_vec_i(trig_vec_i[2**SEL_W-1:0]),
    .sel_i     (sel),
    .mode_i    (mode),
    .en_i      (en),
    .evt_o     (evt)
  );

  dtg_burst_ctrl #(.CNT_W(CNT_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en),
    .kill_i   (dis_wr),
    .evt_i    (evt),
    .cnt_i    (cnt),
    .dack_i   (dack_i),
    .ovr_clr_i(ovr_clr_i),
    .dreq_o   (dreq_o),
    .ovr_o    (ovr)
  );

  assign ovr_flag_o = ovr;
  assign irq_o      = ovr & oie;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (ovr_flag_o && cfg_rdata_o[OIE_BIT])); // R7

endmodule

// File: tb/sim_dtg_channel.sv
module sim_dtg_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] trig = '0;
  logic        dreq;
  logic        dack = 1'b0;
  logic        ovr;
  logic        clr = 1'b0;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dtg_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .trig_vec_i(trig), .dreq_o(dreq), .dack_i(dack),
    .ovr_flag_o(ovr), .ovr_clr_i(clr), .irq_o(irq)
  );

  function automatic logic [31:0] pack(int sel, bit oie, bit en, int mode, int cnt);
    logic [31:0] w = '0;
    w[4:0]   = sel[4:0];
    w[8]     = oie;
    w[16]    = en;
    w[18:17] = mode[1:0];
    w[23:19] = cnt[4:0];
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic setup(int sel, bit oie, int mode, int cnt);
    wr(pack(sel, oie, 1'b0, mode, cnt));
    wr(pack(sel, oie, 1'b1, mode, cnt));
  endtask

  // Acknowledge every request until the line has been quiet for a while.
  task automatic run_burst(output int n);
    int idle = 0;
    n = 0;
    while (idle < 12) begin
      @(negedge clk);
      if (dreq) begin dack = 1'b1; n++; idle = 0; end
      else begin
        dack = 1'b0; idle++;
        if (n > 0 && idle > 5) break;
      end
    end
    dack = 1'b0;
  endtask

  task automatic quiet(int cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (dreq) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    chk(rdata == 0, "R1 reset rdata", rdata, 0);
    chk(!dreq && !ovr && !irq, "R1 reset outputs", {dreq, ovr, irq}, 0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    chk(rdata == 32'h00FF_011F, "R1 layout", rdata, 32'h00FF_011F);
    wr(32'h0);
    chk(rdata == pack(0, 0, 0, 0, 31), "R5 count kept on disabling write", rdata, pack(0, 0, 0, 0, 31));
    wr(32'h0);
    chk(rdata == 0, "R1 cleared", rdata, 0);
  endtask

  task automatic t_rise();
    int n;
    setup(5, 0, 1, 3);
    @(negedge clk); trig[5] = 1'b1;
    run_burst(n);
    chk(n == 4, "R4 rising burst count", n, 4);
    trig[5] = 1'b0;
    run_burst(n);
    chk(n == 0, "R3 rising mode ignores fall", n, 0);
    wr(0);
  endtask

  task automatic t_fall();
    int n;
    setup(12, 0, 2, 0);
    @(negedge clk); trig[12] = 1'b1;
    run_burst(n);
    chk(n == 0, "R3 falling mode ignores rise", n, 0);
    trig[12] = 1'b0;
    run_burst(n);
    chk(n == 1, "R3 falling mode fires", n, 1);
    wr(0);
  endtask

  task automatic t_both();
    int n;
    setup(29, 0, 3, 2);
    @(negedge clk); trig[29] = 1'b1;
    run_burst(n);
    chk(n == 3, "R3 both mode rise", n, 3);
    trig[29] = 1'b0;
    run_burst(n);
    chk(n == 3, "R3 both mode fall", n, 3);
    wr(0);
  endtask

  task automatic t_none();
    bit seen;
    setup(0, 0, 0, 1);
    @(negedge clk); trig[0] = 1'b1;
    quiet(8, seen);
    trig[0] = 1'b0;
    quiet(8, seen);
    chk(!seen, "R3 mode 0 silent", seen, 0);
    wr(0);
  endtask

  task automatic t_reserved();
    bit seen, s2;
    setup(30, 0, 3, 0);
    @(negedge clk); trig = 32'hFFFF_FFFF;
    quiet(8, seen);
    trig = '0;
    quiet(8, s2);
    chk(!seen && !s2, "R2 code 30 silent", {seen, s2}, 0);
    setup(31, 0, 3, 0);
    @(negedge clk); trig = 32'hFFFF_FFFF;
    quiet(8, seen);
    trig = '0;
    quiet(8, s2);
    chk(!seen && !s2, "R2 code 31 silent", {seen, s2}, 0);
    wr(0);
  endtask

  task automatic t_lock();
    int n;
    setup(7, 0, 1, 1);
    wr(pack(7, 1, 1, 1, 9));
    chk(rdata == pack(7, 1, 1, 1, 1), "R5 count locked, others written", rdata, pack(7, 1, 1, 1, 1));
    @(negedge clk); trig[7] = 1'b1;
    run_burst(n);
    chk(n == 2, "R5 burst uses locked count", n, 2);
    trig[7] = 1'b0;
    wr(0);
  endtask

  task automatic t_hold();
    bit held = 1'b1;
    int n;
    setup(3, 0, 1, 1);
    @(negedge clk); trig[3] = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!dreq) held = 1'b0;
    end
    chk(held, "R10 request held without ack", held, 1);
    run_burst(n);
    chk(n == 2, "R10 one request per ack", n, 2);
    trig[3] = 1'b0;
    wr(0);
  endtask

  task automatic t_overrun();
    int n;
    bit seen;
    setup(9, 1, 3, 2);
    @(negedge clk); trig[9] = 1'b1;
    repeat (4) @(negedge clk);
    chk(dreq && !ovr, "R6 burst pending, no overrun yet", {dreq, ovr}, 2'b10);
    trig[9] = 1'b0;
    repeat (5) @(negedge clk);
    chk(ovr, "R6 overrun flag set", ovr, 1);
    chk(irq, "R7 irq with enable", irq, 1);
    run_burst(n);
    chk(n == 3, "R8 dropped event does not extend", n, 3);
    quiet(6, seen);
    chk(!seen, "R8 no restart after burst", seen, 0);
    chk(ovr, "R8 flag sticky", ovr, 1);
    wr(pack(9, 0, 1, 3, 2));
    chk(!irq && ovr, "R7 irq masked", {irq, ovr}, 2'b01);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(!ovr && !irq, "R8 flag cleared by strobe", {ovr, irq}, 0);
    wr(0);
  endtask

  task automatic t_abort();
    bit seen;
    setup(10, 0, 1, 7);
    @(negedge clk); trig[10] = 1'b1;
    repeat (4) @(negedge clk);
    dack = 1'b1;
    repeat (2) @(negedge clk);
    dack = 1'b0;
    chk(dreq, "R9 burst still running", dreq, 1);
    wr(pack(10, 0, 0, 1, 7));
    chk(!dreq, "R9 request dropped on disable", dreq, 0);
    wr(pack(10, 0, 1, 1, 7));
    quiet(8, seen);
    chk(!seen, "R9 nothing resumes on re-enable", seen, 0);
    trig[10] = 1'b0;
    wr(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_both();
    t_none();
    t_reserved();
    t_lock();
    t_hold();
    t_overrun();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule